// File: doc/BRIEF.md
# Elementwise Two-Operand Integer ALU

This block applies one integer operation to a pair of 32-bit operands per beat. An 8-bit selector chooses the operation. A signedness flag sets how the generic operations read their operands. Beats enter through a valid/ready handshake. Each accepted beat yields one registered result beat, which is held until the consumer takes it.

The selector space has two separate bands. The low band (0x00 to 0x19) holds generic operations: pass-through, bitwise, shifts, wrapping arithmetic, max/min, compares, logical ops, absolute difference and absolute value. Max/min, the compares, absolute difference and absolute value in this band follow the signedness flag. The high band starts at 0xC4, where bits [7:6] are 11. It holds integer-engine variants whose signedness is fixed by the code itself, and there the flag is ignored. Any other code produces an error beat with a zero result.

Top module: `ew_int_alu`

## Requirements
- R1: A beat is accepted when in_valid_i and in_ready_o are both high. Its result appears with out_valid_o on the next cycle. in_ready_o is high whenever out_valid_o is low or out_ready_i is high. While out_valid_o is high and out_ready_i is low, result_o and err_o hold their values.
- R2: After reset, out_valid_o is 0 and in_ready_o is 1.
- R3: Code 0x00 returns operand A. 0x01 returns ~A. 0x0A returns A&B, 0x0B returns A|B and 0x0C returns A^B.
- R4: The shift amount is B[4:0]. Codes 0x02 and 0x10 shift A left. 0x03 shifts A right and fills with copies of A[31]. 0x11 shifts A right and fills with zeros.
- R5: Add (0x04, 0xC4) and subtract A−B (0x05, 0xC6) wrap modulo 2^32. Multiply (0x06, 0xC5, 0xDB) returns the low 32 bits of the product.
- R6: In the low band, signed_i=1 reads the operands as two's complement and signed_i=0 reads them as unsigned. Under that reading: 0x08 is max and 0x09 is min. 0x12 eq, 0x13 gt, 0x14 ge, 0x15 le, 0x16 lt and 0x18 ne compare A with B. 0x17 returns |A−B| (max minus min). 0x19 returns |A| when signed (0x80000000 stays 0x80000000) and A unchanged when unsigned.
- R7: Codes 0x0D, 0x0E and 0x0F return the logical AND, OR and XOR of (A≠0) and (B≠0).
- R8: These high-band codes treat the operands as signed whatever signed_i says: 0xCF max, 0xD0 min, 0xD1 gt, 0xD2 ge, 0xD3 le, 0xD4 lt, 0xCD |A−B| and 0xCE |A|. 0xCB returns the larger of |A| and |B|, and 0xCC returns the smaller; the magnitudes are compared as unsigned.
- R9: These high-band codes treat the operands as unsigned whatever signed_i says: 0xD5 max, 0xD6 min, 0xD7 gt, 0xD8 ge, 0xD9 le and 0xDA lt. 0xC9 is eq and 0xCA is ne.
- R10: Every compare and logical code returns 0 or 1 in bit 0, with bits [31:1] zero.
- R11: Any code not listed in R3 to R9 returns err_o=1 and result_o=0 for that beat. Listed codes return err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat present |
| in_ready_o | output | 1 | Block can take a beat |
| op_i | input | 8 | Operation selector |
| signed_i | input | 1 | Signed reading for the low-band ops that depend on it |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| out_valid_o | output | 1 | Result beat present |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 32 | Result |
| err_o | output | 1 | Unsupported selector on this beat |

## Verification
The bench builds the block with its default 32-bit data width. At this width the sign-boundary operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, and shift amounts of 0 and 31, can all be driven directly. That reaches the cases where signed and unsigned compares disagree, where the absolute value of the most negative number wraps, and where the shifts fill differently. One pass sends every one of the 256 selector codes, so the error band is covered in full. Random stalls on the output side exercise the hold behaviour.

// File: rtl/ew_alu_pkg.sv
package ew_alu_pkg;
  typedef enum logic [4:0] {
    K_PASS, K_NOT, K_AND, K_OR, K_XOR, K_SLL, K_SRA, K_SRL,
    K_ADD, K_SUB, K_MUL, K_MAX, K_MIN, K_EQ, K_NE, K_GT, K_GE,
    K_LE, K_LT, K_LAND, K_LOR, K_LXOR, K_ADIFF, K_ABS, K_AMAX,
    K_AMIN, K_ERR
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  sgn;
    logic  boolean;
  } dec_t;
endpackage

// File: rtl/ew_alu_decode.sv
module ew_alu_decode
  import ew_alu_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0] op_i,
  input  logic           signed_i,
  output dec_t           dec_o
);
  always_comb begin
    dec_o.kind = K_ERR;
    dec_o.sgn  = signed_i;
    unique case (op_i)
      8'h00: dec_o.kind = K_PASS;
      8'h01: dec_o.kind = K_NOT;
      8'h02: dec_o.kind = K_SLL;
      8'h03: dec_o.kind = K_SRA;
      8'h04: dec_o.kind = K_ADD;
      8'h05: dec_o.kind = K_SUB;
      8'h06: dec_o.kind = K_MUL;
      8'h08: dec_o.kind = K_MAX;
      8'h09: dec_o.kind = K_MIN;
      8'h0A: dec_o.kind = K_AND;
      8'h0B: dec_o.kind = K_OR;
      8'h0C: dec_o.kind = K_XOR;
      8'h0D: dec_o.kind = K_LAND;
      8'h0E: dec_o.kind = K_LOR;
      8'h0F: dec_o.kind = K_LXOR;
      8'h10: dec_o.kind = K_SLL;
      8'h11: dec_o.kind = K_SRL;
      8'h12: dec_o.kind = K_EQ;
      8'h13: dec_o.kind = K_GT;
      8'h14: dec_o.kind = K_GE;
      8'h15: dec_o.kind = K_LE;
      8'h16: dec_o.kind = K_LT;
      8'h17: dec_o.kind = K_ADIFF;
      8'h18: dec_o.kind = K_NE;
      8'h19: dec_o.kind = K_ABS;
      // integer band: signedness fixed by code
      8'hC4: dec_o.kind = K_ADD;
      8'hC5: dec_o.kind = K_MUL;
      8'hC6: dec_o.kind = K_SUB;
      8'hC9: dec_o.kind = K_EQ;
      8'hCA: dec_o.kind = K_NE;
      8'hCB: begin dec_o.kind = K_AMAX;  dec_o.sgn = 1'b1; end
      8'hCC: begin dec_o.kind = K_AMIN;  dec_o.sgn = 1'b1; end
      8'hCD: begin dec_o.kind = K_ADIFF; dec_o.sgn = 1'b1; end
      8'hCE: begin dec_o.kind = K_ABS;   dec_o.sgn = 1'b1; end
      8'hCF: begin dec_o.kind = K_MAX;   dec_o.sgn = 1'b1; end
      8'hD0: begin dec_o.kind = K_MIN;   dec_o.sgn = 1'b1; end
      8'hD1: begin dec_o.kind = K_GT;    dec_o.sgn = 1'b1; end
      8'hD2: begin dec_o.kind = K_GE;    dec_o.sgn = 1'b1; end
      8'hD3: begin dec_o.kind = K_LE;    dec_o.sgn = 1'b1; end
      8'hD4: begin dec_o.kind = K_LT;    dec_o.sgn = 1'b1; end
      8'hD5: begin dec_o.kind = K_MAX;   dec_o.sgn = 1'b0; end
      8'hD6: begin dec_o.kind = K_MIN;   dec_o.sgn = 1'b0; end
      8'hD7: begin dec_o.kind = K_GT;    dec_o.sgn = 1'b0; end
      8'hD8: begin dec_o.kind = K_GE;    dec_o.sgn = 1'b0; end
      8'hD9: begin dec_o.kind = K_LE;    dec_o.sgn = 1'b0; end
      8'hDA: begin dec_o.kind = K_LT;    dec_o.sgn = 1'b0; end
      8'hDB: dec_o.kind = K_MUL;
      default: dec_o.kind = K_ERR;
    endcase
    dec_o.boolean = dec_o.kind inside {K_EQ, K_NE, K_GT, K_GE, K_LE, K_LT,
                                       K_LAND, K_LOR, K_LXOR};
  end
endmodule

// File: rtl/ew_alu_core.sv
module ew_alu_core
  import ew_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  dec_t         dec_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         err_o
);
  localparam int SHW = $clog2(W);

  logic [W-1:0]   flip, abs_a, abs_b, max_v, min_v;
  logic [SHW-1:0] shamt;
  logic           lt, eq, mag_lt, a_nz, b_nz;

  assign flip   = {dec_i.sgn, {(W-1){1'b0}}};
  assign lt     = (a_i ^ flip) < (b_i ^ flip);
  assign eq     = a_i == b_i;
  assign abs_a  = (dec_i.sgn && a_i[W-1]) ? -a_i : a_i;
  assign abs_b  = (dec_i.sgn && b_i[W-1]) ? -b_i : b_i;
  assign mag_lt = abs_a < abs_b;
  assign max_v  = lt ? b_i : a_i;
  assign min_v  = lt ? a_i : b_i;
  assign shamt  = b_i[SHW-1:0];
  assign a_nz   = |a_i;
  assign b_nz   = |b_i;

  function automatic logic [W-1:0] bit1(input logic v);
    return {{(W-1){1'b0}}, v};
  endfunction

  always_comb begin
    err_o = 1'b0;
    unique case (dec_i.kind)
      K_PASS:  res_o = a_i;
      K_NOT:   res_o = ~a_i;
      K_AND:   res_o = a_i & b_i;
      K_OR:    res_o = a_i | b_i;
      K_XOR:   res_o = a_i ^ b_i;
      K_SLL:   res_o = a_i << shamt;
      K_SRA:   res_o = $unsigned($signed(a_i) >>> shamt);
      K_SRL:   res_o = a_i >> shamt;
      K_ADD:   res_o = a_i + b_i;
      K_SUB:   res_o = a_i - b_i;
      K_MUL:   res_o = a_i * b_i;
      K_MAX:   res_o = max_v;
      K_MIN:   res_o = min_v;
      K_EQ:    res_o = bit1(eq);
      K_NE:    res_o = bit1(!eq);
      K_GT:    res_o = bit1(!lt && !eq);
      K_GE:    res_o = bit1(!lt);
      K_LE:    res_o = bit1(lt || eq);
      K_LT:    res_o = bit1(lt);
      K_LAND:  res_o = bit1(a_nz && b_nz);
      K_LOR:   res_o = bit1(a_nz || b_nz);
      K_LXOR:  res_o = bit1(a_nz ^ b_nz);
      K_ADIFF: res_o = max_v - min_v;
      K_ABS:   res_o = abs_a;
      K_AMAX:  res_o = mag_lt ? abs_b : abs_a;
      K_AMIN:  res_o = mag_lt ? abs_a : abs_b;
      default: begin res_o = '0; err_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/ew_int_alu.sv
module ew_int_alu
  import ew_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int OPW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [OPW-1:0] op_i,
  input  logic           signed_i,
  input  logic [W-1:0]   opa_i,
  input  logic [W-1:0]   opb_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [W-1:0]   result_o,
  output logic           err_o
);
  dec_t         dec;
  logic [W-1:0] res_d;
  logic         err_d, bool_q, accept;

  ew_alu_decode #(.OPW(OPW)) i_decode (
    .op_i(op_i), .signed_i(signed_i), .dec_o(dec)
  );

  ew_alu_core #(.W(W)) i_core (
    .dec_i(dec), .a_i(opa_i), .b_i(opb_i), .res_o(res_d), .err_o(err_d)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      err_o       <= 1'b0;
      bool_q      <= 1'b0;
    end else begin
      if (in_ready_o) out_valid_o <= in_valid_i;
      if (accept) begin
        result_o <= res_d;
        err_o    <= err_d;
        bool_q   <= dec.boolean;
      end
    end
  end

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(err_o));
  assert_bool_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && bool_q |-> result_o[W-1:1] == '0);
  assert_err_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && err_o |-> result_o == '0);
  assert_err_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_o, bool_q}));
endmodule

// File: tb/test_ew_int_alu.sv
module test_ew_int_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        in_valid_i = 0, in_ready_o, signed_i = 0;
  logic [7:0]  op_i = 0;
  logic [31:0] opa_i = 0, opb_i = 0, result_o;
  logic        out_valid_o, out_ready_i = 0, err_o;

  int checks = 0, fails = 0;

  logic [31:0] exp_res_q[$];
  logic        exp_err_q[$];
  string       exp_tag_q[$];
  logic [7:0]  exp_op_q[$];

  logic        stalled = 0;
  logic [31:0] held_res;
  logic        held_err;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ew_int_alu i_ew_int_alu (.*);

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mag(input logic [31:0] x);
    return x[31] ? (32'd0 - x) : x;
  endfunction

  function automatic bit less(input logic [31:0] a, b, input bit s);
    if (s) return $signed(a) < $signed(b);
    return a < b;
  endfunction

  function automatic void model(input logic [7:0] op, input logic [31:0] a, b,
                                input bit sflag, output logic [31:0] r,
                                output bit e, output string tag);
    bit s = sflag;
    e = 0; r = 0; tag = "R11";
    if (op >= 8'hCB && op <= 8'hD4) s = 1;
    if (op >= 8'hD5 && op <= 8'hDA) s = 0;
    case (op)
      8'h00: begin r = a;      tag = "R3"; end
      8'h01: begin r = ~a;     tag = "R3"; end
      8'h0A: begin r = a & b;  tag = "R3"; end
      8'h0B: begin r = a | b;  tag = "R3"; end
      8'h0C: begin r = a ^ b;  tag = "R3"; end
      8'h02, 8'h10: begin r = a << b[4:0]; tag = "R4"; end
      8'h03: begin r = $unsigned($signed(a) >>> b[4:0]); tag = "R4"; end
      8'h11: begin r = a >> b[4:0]; tag = "R4"; end
      8'h04, 8'hC4: begin r = a + b; tag = "R5"; end
      8'h05, 8'hC6: begin r = a - b; tag = "R5"; end
      8'h06, 8'hC5, 8'hDB: begin r = 32'(longint'(a) * longint'(b)); tag = "R5"; end
      8'h0D: begin r = 32'((a != 0) && (b != 0)); tag = "R7"; end
      8'h0E: begin r = 32'((a != 0) || (b != 0)); tag = "R7"; end
      8'h0F: begin r = 32'((a != 0) != (b != 0)); tag = "R7"; end
      8'h08, 8'hCF, 8'hD5: r = less(a, b, s) ? b : a;
      8'h09, 8'hD0, 8'hD6: r = less(a, b, s) ? a : b;
      8'h12, 8'hC9: r = 32'(a == b);
      8'h18, 8'hCA: r = 32'(a != b);
      8'h13, 8'hD1, 8'hD7: r = 32'(less(b, a, s));
      8'h14, 8'hD2, 8'hD8: r = 32'(!less(a, b, s));
      8'h15, 8'hD3, 8'hD9: r = 32'(!less(b, a, s));
      8'h16, 8'hD4, 8'hDA: r = 32'(less(a, b, s));
      8'h17, 8'hCD: r = less(a, b, s) ? b - a : a - b;
      8'h19, 8'hCE: r = s ? mag(a) : a;
      8'hCB: r = (mag(a) < mag(b)) ? mag(b) : mag(a);
      8'hCC: r = (mag(a) < mag(b)) ? mag(a) : mag(b);
      default: e = 1;
    endcase
    if (!e && tag == "R11") tag = (op >= 8'hC4) ? ((op >= 8'hD5 || op == 8'hC9 || op == 8'hCA) ? "R9" : "R8") : "R6";
  endfunction

  function automatic logic [31:0] pick_operand();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      4: return $urandom_range(0, 40);
      default: return $urandom;
    endcase
  endfunction

  logic [7:0] ops_ok[$] = '{8'h00,8'h01,8'h02,8'h03,8'h04,8'h05,8'h06,8'h08,8'h09,8'h0A,
    8'h0B,8'h0C,8'h0D,8'h0E,8'h0F,8'h10,8'h11,8'h12,8'h13,8'h14,8'h15,8'h16,8'h17,8'h18,
    8'h19,8'hC4,8'hC5,8'hC6,8'hC9,8'hCA,8'hCB,8'hCC,8'hCD,8'hCE,8'hCF,8'hD0,8'hD1,8'hD2,
    8'hD3,8'hD4,8'hD5,8'hD6,8'hD7,8'hD8,8'hD9,8'hDA,8'hDB,8'h07,8'h1A,8'hC7,8'hDC,8'hFF};

  // one cycle: drive, settle, score handshakes (edge follows)
  task automatic cycle(input bit v, input logic [7:0] op, input logic [31:0] a, b,
                       input bit s, input bit rdy);
    logic [31:0] r; bit e; string tag;
    @(negedge clk_i);
    if (stalled) begin
      check(out_valid_o === 1'b1 && result_o === held_res && err_o === held_err,
            "R1 hold", {31'd0, err_o, result_o}, {31'd0, held_err, held_res});
    end
    in_valid_i = v; op_i = op; opa_i = a; opb_i = b; signed_i = s; out_ready_i = rdy;
    #1;
    check(in_ready_o === (!out_valid_o || out_ready_i), "R1 ready",
          64'(in_ready_o), 64'(!out_valid_o || out_ready_i));
    stalled = out_valid_o && !out_ready_i;
    held_res = result_o; held_err = err_o;
    if (out_valid_o && out_ready_i) begin
      if (exp_res_q.size() == 0) check(0, "R1 spurious", 64'(result_o), 0);
      else begin
        logic [31:0] er = exp_res_q.pop_front();
        logic ee = exp_err_q.pop_front();
        string t = exp_tag_q.pop_front();
        logic [7:0] eo = exp_op_q.pop_front();
        check(result_o === er && err_o === ee, $sformatf("%s op %h", t, eo),
              {31'd0, err_o, result_o}, {31'd0, ee, er});
        if (eo inside {8'h0D,8'h0E,8'h0F,8'h12,8'h13,8'h14,8'h15,8'h16,8'h18,8'hC9,8'hCA,
                       [8'hD1:8'hD4],[8'hD7:8'hDA]})
          check(result_o[31:1] === 31'd0, "R10 upper bits", 64'(result_o), 64'(result_o[0]));
      end
    end
    if (v && in_ready_o) begin
      model(op, a, b, s, r, e, tag);
      exp_res_q.push_back(r); exp_err_q.push_back(e);
      exp_tag_q.push_back(tag); exp_op_q.push_back(op);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check(out_valid_o === 1'b0 && in_ready_o === 1'b1, "R2 reset",
          {out_valid_o, in_ready_o}, 2'b01);
    rst_ni = 1;
    // directed corners
    cycle(1, 8'h03, 32'h8000_0000, 32'd31, 0, 1);    // R4 -> all ones
    cycle(1, 8'h11, 32'h8000_0000, 32'd31, 0, 1);    // R4 -> 1
    cycle(1, 8'h02, 32'h0000_0001, 32'h0000_0020, 0, 1); // R4 shamt 0
    cycle(1, 8'h19, 32'h8000_0000, 0, 1, 1);          // R6 abs wrap
    cycle(1, 8'h16, 32'hFFFF_FFFF, 32'd1, 1, 1);      // R6 signed lt
    cycle(1, 8'h16, 32'hFFFF_FFFF, 32'd1, 0, 1);      // R6 unsigned lt
    cycle(1, 8'hD5, 32'hFFFF_FFFF, 32'd1, 1, 1);      // R9 ignores flag
    cycle(1, 8'hCF, 32'hFFFF_FFFF, 32'd1, 0, 1);      // R8 ignores flag
    cycle(1, 8'hCB, 32'h8000_0000, 32'h7FFF_FFFF, 0, 1); // R8 abs-max
    cycle(1, 8'hC5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1); // R5 low product
    cycle(1, 8'h04, 32'hFFFF_FFFF, 32'd2, 0, 1);      // R5 wrap
    // every code once (R11 sweep)
    for (int c = 0; c < 256; c++)
      cycle(1, 8'(c), pick_operand(), pick_operand(), 1'($urandom), 1);
    // random traffic with stalls
    for (int n = 0; n < 4000; n++)
      cycle(1'($urandom_range(0, 3) != 0), ops_ok[$urandom_range(0, ops_ok.size() - 1)],
            pick_operand(), pick_operand(), 1'($urandom), 1'($urandom_range(0, 2) != 0));
    // drain
    for (int n = 0; n < 4; n++) cycle(0, 0, 0, 0, 0, 1);
    check(exp_res_q.size() == 0, "R1 drain", 64'(exp_res_q.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule